// File: doc/BRIEF.md
# Randomized stride prefetch engine

This block sits beside a level-one data cache and turns each reported miss (a program counter and a byte address) into a burst of prefetch line addresses. A table keyed by the program counter remembers, for each load site, the line it last missed on and the line distance between its last two misses. When a new miss repeats that distance, the engine predicts the following lines along the same stride. Otherwise it falls back to the lines directly after the missed one.

The burst length and the order of the burst are both random. A 16-bit linear feedback shift register, advanced every clock, chooses a length between one and the configured maximum when the burst is started. It then draws the issue order slot by slot from the lines still pending. Lines leave on a valid/ready port, one per clock while the consumer accepts. A miss that arrives while a burst is still pending or held on the port still trains the table but starts no burst. All addresses are line aligned, and the byte offset of a miss is ignored.

Top module: `rnd_stride_pf`

## Requirements
- R1: After reset, `pf_valid` stays low until a miss has been reported.
- R2: A miss whose program counter is not in the table issues a burst of D lines `L+1 .. L+D`, where L is the miss line (`miss_addr` shifted right by 6).
- R3: When the program counter is in the table and the new line minus the stored line equals the stored non-zero stride S, the burst is `L+S, L+2S, .. L+D*S` (modulo the line-number width). Negative strides are included.
- R4: D lies in 1..MAX_DEGREE (10 by default), and every value in that range occurs over a long run of misses.
- R5: Each line of a burst is issued exactly once. Over a long run, bursts are seen in an order other than ascending multiples.
- R6: A stored stride of zero never counts as a match: repeated misses to one line take the next-line fallback.
- R7: With `pf_ready` held high, the D lines of a burst leave on D consecutive clocks.
- R8: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` holds its value on the next clock.
- R9: A miss that arrives while a burst is pending starts no burst, but it still updates that program counter's stored line and stride.
- R10: A program counter missing in the table takes an entry by round-robin over the ENTRIES slots, with stride zero, evicting the oldest allocation.
- R11: `pf_addr` always has its low 6 bits at zero, and the offset bits of `miss_addr` have no effect on the lines issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | A cache miss is reported this clock |
| miss_pc | input | PC_W | Program counter of the missing load |
| miss_addr | input | ADDR_W | Byte address of the miss |
| pf_valid | output | 1 | A prefetch line address is offered |
| pf_ready | input | 1 | Consumer takes the offered address |
| pf_addr | output | ADDR_W | Line-aligned prefetch byte address |

## Verification
A corrupted stride entry shows at the port on the next burst for that program counter, because every issued line of that burst leaves the expected arithmetic progression. A broken draw from the pending slots shows as a duplicated or missing multiple within the D clocks of a single burst. A wrong round-robin pointer shows only after ENTRIES further allocations, when a trained site either wrongly keeps its stride or wrongly loses it. The bench therefore compares the issued lines as a set per burst, because the order is random and cannot be predicted.

// File: rtl/rnd_stride_pf.sv
`timescale 1ns/1ps
module rnd_stride_pf #(
  parameter int PC_W = 32,
  parameter int ADDR_W = 32,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES = 256,
  parameter int MAX_DEGREE = 10,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [PC_W-1:0]   miss_pc,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int OFS    = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFS;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int SLOT_W = $clog2(MAX_DEGREE + 1);

  logic [15:0] lfsr;
  wire  [15:0] lfsr_nx = {1'b0, lfsr[15:1]} ^ ({16{lfsr[0]}} & 16'hB400);

  logic [ENTRIES-1:0] tv;
  logic [PC_W-1:0]    tpc     [ENTRIES];
  logic [LINE_W-1:0]  tline   [ENTRIES];
  logic [LINE_W-1:0]  tstride [ENTRIES];
  logic [IDX_W-1:0]   rr, hidx;
  logic               hit;

  wire [LINE_W-1:0] mline = miss_addr[ADDR_W-1:OFS];

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (tv[i] && tpc[i] == miss_pc && !hit) begin
        hit  = 1'b1;
        hidx = IDX_W'(i);
      end
  end

  wire [LINE_W-1:0] delta = mline - tline[hidx];
  wire match = hit && (delta == tstride[hidx]) && (tstride[hidx] != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tv <= '0;
      rr <= '0;
    end else if (miss_valid && !hit) begin
      tv[rr] <= 1'b1;
      rr     <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + IDX_W'(1);
    end

  always_ff @(posedge clk)
    if (miss_valid) begin
      if (hit) begin
        tline[hidx]   <= mline;
        tstride[hidx] <= delta;
      end else begin
        tpc[rr]     <= miss_pc;
        tline[rr]   <= mline;
        tstride[rr] <= '0;
      end
    end

  logic [SLOT_W-1:0] slot [MAX_DEGREE];
  logic [SLOT_W-1:0] cnt, out_mult;
  logic [LINE_W-1:0] base, step;

  wire busy   = (cnt != '0) || pf_valid;
  wire accept = miss_valid && !busy;
  wire take   = (cnt != '0) && (!pf_valid || pf_ready);

  wire [SLOT_W-1:0] deg    = SLOT_W'((32'(lfsr) % MAX_DEGREE) + 1);
  wire [SLOT_W-1:0] cnt_nz = (cnt == '0) ? SLOT_W'(1) : cnt;
  wire [SLOT_W-1:0] pick   = SLOT_W'(32'(lfsr[15:8]) % 32'(cnt_nz));
  wire [SLOT_W-1:0] last   = cnt_nz - SLOT_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lfsr     <= SEED;
      cnt      <= '0;
      out_mult <= '0;
      pf_valid <= 1'b0;
      base     <= '0;
      step     <= '0;
      for (int i = 0; i < MAX_DEGREE; i++) slot[i] <= '0;
    end else begin
      lfsr <= lfsr_nx;
      if (accept) begin
        cnt  <= deg;
        base <= mline;
        step <= match ? tstride[hidx] : LINE_W'(1);
        for (int i = 0; i < MAX_DEGREE; i++) slot[i] <= SLOT_W'(i + 1);
      end else if (take) begin
        out_mult   <= slot[pick];
        slot[pick] <= slot[last];
        cnt        <= cnt - SLOT_W'(1);
      end
      if (take) pf_valid <= 1'b1;
      else if (pf_ready) pf_valid <= 1'b0;
    end

  assign pf_addr = {base + LINE_W'(out_mult) * step, {OFS{1'b0}}};

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));
  a_r4_depth: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= SLOT_W'(MAX_DEGREE));
  a_r7_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && (!pf_valid || pf_ready) |=> pf_valid);
  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && busy |=> cnt <= $past(cnt));
  a_r4_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0);
endmodule

// File: tb/tb_rnd_stride_pf.sv
`timescale 1ns/1ps
module tb_rnd_stride_pf;
  localparam int MAXD = 10;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, miss_valid, pf_ready, pf_valid;
  logic [31:0] miss_pc, miss_addr, pf_addr;

  rnd_stride_pf #(.ENTRIES(4), .MAX_DEGREE(MAXD)) dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_pc(miss_pc),
    .miss_addr(miss_addr), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr));

  int total = 0, bad = 0, cyc = 0;
  int n, first_c, last_c;
  bit misalign;
  logic [25:0] got [32];
  bit deg_seen [MAXD+1];
  bit any_shuffled = 0;
  bit st_prev = 0;
  logic [31:0] st_addr;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    #1;
    if (st_prev) begin
      total++;
      if (!(pf_valid && pf_addr == st_addr)) begin
        bad++;
        $display("FAIL R8 held offer changed: valid=%0b addr=%h exp=%h", pf_valid, pf_addr, st_addr);
      end
    end
    st_prev = pf_valid && !pf_ready;
    st_addr = pf_addr;
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired: cycles=%0d expected<150000", cyc);
    finish_run();
  end

  task automatic miss(input logic [31:0] pc, input logic [31:0] addr);
    @(negedge clk);
    miss_valid = 1'b1; miss_pc = pc; miss_addr = addr;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic collect();
    int idle = 0;
    n = 0; misalign = 0; first_c = 0; last_c = 0;
    while (idle < 12) begin
      if (pf_valid && pf_ready) begin
        if (n < 32) got[n] = pf_addr[31:6];
        if (pf_addr[5:0] != 6'd0) misalign = 1;
        if (n == 0) first_c = cyc;
        last_c = cyc;
        n++; idle = 0;
      end else idle++;
      @(negedge clk);
    end
  endtask

  task automatic check_set(input string tag, input logic [25:0] b, input logic [25:0] s, input bit contig);
    bit ok, asc;
    bit used [MAXD+1];
    ok = (n >= 1 && n <= MAXD) && !misalign;
    asc = 1;
    for (int k = 0; k <= MAXD; k++) used[k] = 0;
    if (ok) for (int i = 0; i < n; i++) begin
      bit f = 0;
      for (int k = 1; k <= n; k++)
        if (!f && !used[k] && got[i] == 26'(b + 26'(k) * s)) begin used[k] = 1; f = 1; end
      if (!f) ok = 0;
      if (got[i] != 26'(b + 26'(i + 1) * s)) asc = 0;
    end
    if (contig && ok && (last_c - first_c != n - 1)) ok = 0;
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: n=%0d first=%h span=%0d misalign=%0b exp first of {%h + k*%h}",
               tag, n, got[0], last_c - first_c, misalign, b, s);
    end else begin
      deg_seen[n] = 1;
      if (!asc) any_shuffled = 1;
    end
  endtask

  initial begin
    int strides [8] = '{1, 2, 3, -1, -4, 7, -9, 10};
    rst_n = 0; miss_valid = 0; pf_ready = 1; miss_pc = 0; miss_addr = 0;
    for (int k = 0; k <= MAXD; k++) deg_seen[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    begin : r1_reset
      bit seen = 0;
      repeat (8) begin @(negedge clk); if (pf_valid) seen = 1; end
      total++;
      if (seen) begin bad++; $display("FAIL R1 valid after reset: got=1 exp=0"); end
    end

    // R2 R4 R5 R7 R11: fallback sweep with unknown PCs and odd offsets
    for (int i = 0; i < 150; i++) begin
      logic [31:0] a = 32'(i * 4096 + 37 + i);
      miss(32'h1000 + 32'(i), a);
      collect();
      check_set("R2/R7/R11 fallback", a[31:6], 26'd1, 1);
    end

    // R3: stride sweep
    for (int j = 0; j < 8; j++) begin
      int lb = 5000 + j * 300;
      int s = strides[j];
      miss(32'h5000 + 32'(j), 32'(lb * 64 + 5));
      collect(); check_set("R10 first miss fallback", 26'(lb), 26'd1, 1);
      miss(32'h5000 + 32'(j), 32'((lb + s) * 64));
      collect(); check_set("R3 second miss fallback", 26'(lb + s), 26'd1, 1);
      miss(32'h5000 + 32'(j), 32'((lb + 2 * s) * 64 + 63));
      collect(); check_set("R3 stride match", 26'(lb + 2 * s), 26'(s), 1);
    end

    // R6: zero stride
    for (int r = 0; r < 3; r++) begin
      miss(32'h6000, 32'(777 * 64 + r * 9));
      collect(); check_set("R6 zero stride fallback", 26'd777, 26'd1, 1);
    end

    // R9: miss while busy trains but starts nothing
    miss(32'h7000, 32'(9000 * 64)); collect(); check_set("R9 setup", 26'd9000, 26'd1, 1);
    miss(32'h7000, 32'(9002 * 64)); collect(); check_set("R9 setup", 26'd9002, 26'd1, 1);
    @(negedge clk); pf_ready = 0;
    miss(32'h7000, 32'(9004 * 64));
    repeat (4) @(negedge clk);
    miss(32'h7000, 32'(9009 * 64));
    repeat (3) @(negedge clk);
    pf_ready = 1;
    collect(); check_set("R9/R8 burst while stalled", 26'd9004, 26'd2, 0);
    miss(32'h7000, 32'(9014 * 64));
    collect(); check_set("R9 table updated by dropped miss", 26'd9014, 26'd5, 1);

    // R8: stall in the middle of a burst with a toggling ready
    miss(32'h7100, 32'(300 * 64));
    n = 0; misalign = 0;
    begin : r8_toggle
      int idle = 0, t = 0;
      while (idle < 12) begin
        pf_ready = (t % 3) != 1;
        #1;
        if (pf_valid && pf_ready) begin got[n] = pf_addr[31:6]; n++; idle = 0; end
        else idle++;
        t++;
        @(negedge clk);
      end
      pf_ready = 1;
    end
    check_set("R8 toggling ready", 26'd300, 26'd1, 0);

    // R10: round robin replacement with four entries
    miss(32'h8000, 32'(2000 * 64)); collect(); check_set("R10 alloc", 26'd2000, 26'd1, 1);
    miss(32'h8000, 32'(2003 * 64)); collect(); check_set("R10 train", 26'd2003, 26'd1, 1);
    for (int q = 0; q < 3; q++) begin
      miss(32'h9000 + 32'(q), 32'(40000 * 64)); collect();
      check_set("R10 filler", 26'd40000, 26'd1, 1);
    end
    miss(32'h8000, 32'(2006 * 64)); collect(); check_set("R10 kept after three allocs", 26'd2006, 26'd3, 1);
    for (int q = 0; q < 4; q++) begin
      miss(32'h9100 + 32'(q), 32'(41000 * 64)); collect();
      check_set("R10 filler", 26'd41000, 26'd1, 1);
    end
    miss(32'h8000, 32'(2009 * 64)); collect(); check_set("R10 evicted after four allocs", 26'd2009, 26'd1, 1);

    begin : r4_r5_summary
      bit all = 1;
      for (int k = 1; k <= MAXD; k++) if (!deg_seen[k]) all = 0;
      total++;
      if (!all) begin bad++; $display("FAIL R4 degree coverage: got incomplete exp all 1..%0d", MAXD); end
      total++;
      if (!any_shuffled) begin bad++; $display("FAIL R5 order: got always ascending exp some permuted"); end
    end
    finish_run();
  end
endmodule